// File: doc/BRIEF.md
# Store-to-Load Alias Detector for Dispatch Groups

This block watches the memory operations that a scheduler places into one dispatch group and flags any load that would read bytes written by the latest store in that group. Each access is described symbolically by two operands and an access size. The second operand is normally a base register tag. The first operand is either a register tag or a signed constant offset, and a flag tells which. The block keeps one store record. A load is checked against it in the same cycle, and the single `hazard` bit tells the scheduler to close the group or to insert padding before the load.

A load aliases the recorded store in three cases. The first is when its operand pair equals the store's. The second is when the pair equals the store's with the two operands swapped. The third is when both accesses use the same second operand and constant first operands, and their byte ranges intersect. A group-end pulse empties the record. Address generation and the memory access itself are outside this block.

Top module: `ldst_alias_guard`

## Requirements
- R1: The 2-bit size code selects the access length: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes. The overlap test uses these lengths.
- R2: A load whose first and second operands (flag and value) both equal those of the recorded store raises `hazard`, whatever the two sizes are.
- R3: A load whose first operand equals the store's second operand, and whose second operand equals the store's first operand, raises `hazard`.
- R4: If the second operands are equal and both first operands carry the constant flag, the accesses cover [offset, offset+length). When the store offset is the lower one, `hazard` is raised if store offset + store length > load offset. Otherwise it is raised if load offset + load length > store offset.
- R5: Constant offsets are 16-bit two's complement values. The overlap sums are formed without wraparound, so a store at +32767 and a load at -32768 do not overlap.
- R6: With no store recorded (after reset, or after a group end with no store in the same cycle), `hazard` stays 0 for every load.
- R7: A store accepted while a record is held replaces that record entirely. Later loads are compared only with the newer store.
- R8: `group_end` empties the record at the next rising clock edge, so a load in the same cycle as `group_end` is still checked. A store presented in the same cycle as `group_end` is recorded and opens the next group.
- R9: `hazard` is combinational from the load inputs in the cycle the load is presented, and it is 0 whenever `ld_valid` is 0.
- R10: Operands match only if their constant flags agree. A register tag and a constant with the same value are different operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, empties the record |
| st_valid | input | 1 | A store is issued this cycle and is recorded at the edge |
| st_a_const | input | 1 | Store first operand is a constant offset (1) or register tag (0) |
| st_a_val | input | 16 | Store first operand value |
| st_b_const | input | 1 | Store second operand is a constant (1) or register tag (0) |
| st_b_val | input | 16 | Store second operand value |
| st_size | input | 2 | Store size code (R1) |
| ld_valid | input | 1 | A load is being checked this cycle |
| ld_a_const | input | 1 | Load first operand is a constant offset (1) or register tag (0) |
| ld_a_val | input | 16 | Load first operand value |
| ld_b_const | input | 1 | Load second operand is a constant (1) or register tag (0) |
| ld_b_val | input | 16 | Load second operand value |
| ld_size | input | 2 | Load size code (R1) |
| group_end | input | 1 | Closes the dispatch group; the record empties at the next edge |
| hazard | output | 1 | The load aliases the recorded store |

## Verification
`hazard` depends on the load inputs with no delay. It also depends on a record that changes only at a rising edge, so any store or group end affects loads starting one cycle later. The bench drives every input just after a falling edge and samples `hazard` 1 ns later, still within that cycle. It updates its own copy of the record at the following rising edge. Checks therefore test same-cycle behaviour for the load and next-cycle behaviour for stores, group ends and reset.

// File: rtl/ldst_alias_pkg.sv
package ldst_alias_pkg;

    parameter int OPND_W = 16;
    localparam int SUM_W = OPND_W + 2;
    localparam int LEN_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              is_const;
        logic [OPND_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        opnd_t     a;
        opnd_t     b;
        acc_size_e size;
    } access_t;

    function automatic logic [LEN_W-1:0] size_bytes(acc_size_e s);
        return LEN_W'(1) << s;
    endfunction

    function automatic logic opnd_same(opnd_t x, opnd_t y);
        return (x.is_const == y.is_const) && (x.val == y.val);
    endfunction

endpackage

// File: rtl/ldst_store_slot.sv
module ldst_store_slot
    import ldst_alias_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    st_valid,
    input  logic    group_end,
    input  access_t st_acc,
    output logic    rec_valid,
    output access_t rec_acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_acc   <= '0;
        end else if (st_valid) begin
            rec_valid <= 1'b1;
            rec_acc   <= st_acc;
        end else if (group_end) begin
            rec_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ldst_range_overlap.sv
module ldst_range_overlap
    import ldst_alias_pkg::*;
(
    input  logic [OPND_W-1:0] st_off,
    input  acc_size_e         st_sz,
    input  logic [OPND_W-1:0] ld_off,
    input  acc_size_e         ld_sz,
    output logic              overlap
);

    logic signed [SUM_W-1:0] st_lo, ld_lo, st_len, ld_len, st_hi, ld_hi;

    always_comb begin
        st_lo  = $signed({{(SUM_W-OPND_W){st_off[OPND_W-1]}}, st_off});
        ld_lo  = $signed({{(SUM_W-OPND_W){ld_off[OPND_W-1]}}, ld_off});
        st_len = $signed({{(SUM_W-LEN_W){1'b0}}, size_bytes(st_sz)});
        ld_len = $signed({{(SUM_W-LEN_W){1'b0}}, size_bytes(ld_sz)});
        st_hi  = st_lo + st_len;
        ld_hi  = ld_lo + ld_len;
        if (st_lo < ld_lo) overlap = (st_hi > ld_lo);
        else               overlap = (ld_hi > st_lo);
    end

endmodule

// File: rtl/ldst_alias_match.sv
module ldst_alias_match
    import ldst_alias_pkg::*;
(
    input  access_t rec_acc,
    input  access_t ld_acc,
    output logic    alias_hit
);

    logic exact_hit, swap_hit, base_same, both_const, range_hit;

    ldst_range_overlap u_range (
        .st_off (rec_acc.a.val),
        .st_sz  (rec_acc.size),
        .ld_off (ld_acc.a.val),
        .ld_sz  (ld_acc.size),
        .overlap(range_hit)
    );

    always_comb begin
        exact_hit  = opnd_same(ld_acc.a, rec_acc.a) && opnd_same(ld_acc.b, rec_acc.b);
        swap_hit   = opnd_same(ld_acc.a, rec_acc.b) && opnd_same(ld_acc.b, rec_acc.a);
        base_same  = opnd_same(ld_acc.b, rec_acc.b);
        both_const = ld_acc.a.is_const && rec_acc.a.is_const;
        alias_hit  = exact_hit || swap_hit || (base_same && both_const && range_hit);
    end

endmodule

// File: rtl/ldst_alias_guard.sv
module ldst_alias_guard
    import ldst_alias_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic              st_a_const,
    input  logic [OPND_W-1:0] st_a_val,
    input  logic              st_b_const,
    input  logic [OPND_W-1:0] st_b_val,
    input  logic [1:0]        st_size,
    input  logic              ld_valid,
    input  logic              ld_a_const,
    input  logic [OPND_W-1:0] ld_a_val,
    input  logic              ld_b_const,
    input  logic [OPND_W-1:0] ld_b_val,
    input  logic [1:0]        ld_size,
    input  logic              group_end,
    output logic              hazard
);

    access_t st_acc, ld_acc, rec_acc;
    logic    rec_valid, alias_hit;

    always_comb begin
        st_acc.a.is_const = st_a_const;
        st_acc.a.val      = st_a_val;
        st_acc.b.is_const = st_b_const;
        st_acc.b.val      = st_b_val;
        st_acc.size       = acc_size_e'(st_size);
        ld_acc.a.is_const = ld_a_const;
        ld_acc.a.val      = ld_a_val;
        ld_acc.b.is_const = ld_b_const;
        ld_acc.b.val      = ld_b_val;
        ld_acc.size       = acc_size_e'(ld_size);
    end

    ldst_store_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .st_valid (st_valid),
        .group_end(group_end),
        .st_acc   (st_acc),
        .rec_valid(rec_valid),
        .rec_acc  (rec_acc)
    );

    ldst_alias_match u_match (
        .rec_acc  (rec_acc),
        .ld_acc   (ld_acc),
        .alias_hit(alias_hit)
    );

    assign hazard = ld_valid && rec_valid && alias_hit;

endmodule

// File: rtl/ldst_alias_guard_chk.sv
module ldst_alias_guard_chk
    import ldst_alias_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_a_const,
    input logic [OPND_W-1:0] st_a_val,
    input logic              st_b_const,
    input logic [OPND_W-1:0] st_b_val,
    input logic              ld_valid,
    input logic              ld_a_const,
    input logic [OPND_W-1:0] ld_a_val,
    input logic              ld_b_const,
    input logic [OPND_W-1:0] ld_b_val,
    input logic              group_end,
    input logic              hazard
);

    logic [OPND_W:0] st_a, st_b, ld_a, ld_b;
    assign st_a = {st_a_const, st_a_val};
    assign st_b = {st_b_const, st_b_val};
    assign ld_a = {ld_a_const, ld_a_val};
    assign ld_b = {ld_b_const, ld_b_val};

    // R9: no load, no hazard
    a_r9_idle_load: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> !hazard);

    // R6 / R8: a group end without a store leaves nothing to match
    a_r6_empty_after_end: assert property (@(posedge clk) disable iff (rst)
        (group_end && !st_valid) |=> !hazard);

    // R2: load repeating the just-recorded operand pair
    a_r2_exact_pair: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> (!(ld_valid && ld_a == $past(st_a) && ld_b == $past(st_b)) || hazard));

    // R3: load with the just-recorded operands swapped
    a_r3_swapped_pair: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> (!(ld_valid && ld_a == $past(st_b) && ld_b == $past(st_a)) || hazard));

endmodule

bind ldst_alias_guard ldst_alias_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_a_const(st_a_const),
    .st_a_val  (st_a_val),
    .st_b_const(st_b_const),
    .st_b_val  (st_b_val),
    .ld_valid  (ld_valid),
    .ld_a_const(ld_a_const),
    .ld_a_val  (ld_a_val),
    .ld_b_const(ld_b_const),
    .ld_b_val  (ld_b_val),
    .group_end (group_end),
    .hazard    (hazard)
);

// File: tb/tb_ldst_alias_guard.sv
module tb_ldst_alias_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0, st_a_const = 0, st_b_const = 0;
    logic [15:0] st_a_val = 0, st_b_val = 0;
    logic [1:0]  st_size = 0;
    logic        ld_valid = 0, ld_a_const = 0, ld_b_const = 0;
    logic [15:0] ld_a_val = 0, ld_b_val = 0;
    logic [1:0]  ld_size = 0;
    logic        group_end = 0;
    logic        hazard;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench copy of the store record
    bit        m_valid = 0;
    bit        m_ac = 0, m_bc = 0;
    bit [15:0] m_av = 0, m_bv = 0;
    bit [1:0]  m_sz = 0;

    always #2 clk = ~clk;

    ldst_alias_guard dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_a_const(st_a_const), .st_a_val(st_a_val),
        .st_b_const(st_b_const), .st_b_val(st_b_val), .st_size(st_size),
        .ld_valid(ld_valid), .ld_a_const(ld_a_const), .ld_a_val(ld_a_val),
        .ld_b_const(ld_b_const), .ld_b_val(ld_b_val), .ld_size(ld_size),
        .group_end(group_end), .hazard(hazard)
    );

    function automatic bit exp_hazard();
        bit exact, swapped, base_eq, ranges;
        int so, lo;
        if (!ld_valid || !m_valid) return 0;
        exact   = ({ld_a_const, ld_a_val} == {m_ac, m_av}) && ({ld_b_const, ld_b_val} == {m_bc, m_bv});
        swapped = ({ld_a_const, ld_a_val} == {m_bc, m_bv}) && ({ld_b_const, ld_b_val} == {m_ac, m_av});
        base_eq = ({ld_b_const, ld_b_val} == {m_bc, m_bv});
        so = int'($signed(m_av));
        lo = int'($signed(ld_a_val));
        if (so < lo) ranges = (so + (1 << m_sz)) > lo;
        else         ranges = (lo + (1 << ld_size)) > so;
        return exact || swapped || (base_eq && ld_a_const && m_ac && ranges);
    endfunction

    // inputs are already set just after a falling edge
    task automatic step(input string req);
        bit e;
        #1;
        e = exp_hazard();
        n_cmp++;
        if (hazard !== e) begin
            n_bad++;
            $display("FAIL %s: hazard=%0b expected %0b at %0t", req, hazard, e, $time);
        end
        @(posedge clk);
        if (rst) m_valid = 0;
        else if (st_valid) begin
            m_valid = 1; m_ac = st_a_const; m_av = st_a_val;
            m_bc = st_b_const; m_bv = st_b_val; m_sz = st_size;
        end else if (group_end) m_valid = 0;
        @(negedge clk);
        st_valid = 0; ld_valid = 0; group_end = 0;
    endtask

    task automatic put_st(input bit ac, input logic [15:0] av, input bit bc, input logic [15:0] bv, input logic [1:0] sz);
        st_valid = 1; st_a_const = ac; st_a_val = av; st_b_const = bc; st_b_val = bv; st_size = sz;
    endtask

    task automatic put_ld(input bit ac, input logic [15:0] av, input bit bc, input logic [15:0] bv, input logic [1:0] sz);
        ld_valid = 1; ld_a_const = ac; ld_a_val = av; ld_b_const = bc; ld_b_val = bv; ld_size = sz;
    endtask

    function automatic logic [15:0] rnd_val();
        case ($urandom_range(0, 5))
            0: return 16'h7FFF - 16'($urandom_range(0, 9));
            1: return 16'h8000 + 16'($urandom_range(0, 9));
            2: return 16'hFFF8 + 16'($urandom_range(0, 7));
            default: return 16'($urandom_range(0, 15));
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        put_ld(0, 16'd0, 0, 16'd0, 2'd0);
        step("R6 reset");
        rst = 0;
        @(negedge clk);
        put_ld(0, 16'd0, 0, 16'd0, 2'd0);
        step("R6 after reset");

        // register pair store
        put_st(0, 16'd3, 0, 16'd4, 2'd2); step("R2 store");
        put_ld(0, 16'd3, 0, 16'd4, 2'd0); step("R2 exact");
        put_ld(0, 16'd4, 0, 16'd3, 2'd3); step("R3 swapped");
        put_ld(1, 16'd3, 0, 16'd4, 2'd2); step("R10 flag mismatch");
        ld_valid = 0; ld_a_const = 0; ld_a_val = 16'd3; ld_b_val = 16'd4; step("R9 idle load");

        // constant offset window, store bytes 8..11 off base r1
        put_st(1, 16'd8, 0, 16'd1, 2'd2); step("R7 overwrite");
        put_ld(0, 16'd3, 0, 16'd4, 2'd2); step("R7 old store gone");
        put_ld(1, 16'd12, 0, 16'd1, 2'd0); step("R4 just above");
        put_ld(1, 16'd11, 0, 16'd1, 2'd0); step("R4 last byte");
        put_ld(1, 16'd4, 0, 16'd1, 2'd2); step("R1 word below");
        put_ld(1, 16'd5, 0, 16'd1, 2'd2); step("R1 word touching");
        put_ld(1, 16'd0, 0, 16'd1, 2'd3); step("R1 dbl below");
        put_ld(1, 16'd1, 0, 16'd1, 2'd3); step("R1 dbl touching");
        put_ld(1, 16'd9, 0, 16'd2, 2'd0); step("R4 other base");

        // signed offsets
        put_st(1, 16'hFFFE, 0, 16'd1, 2'd1); step("R5 store -2");
        put_ld(1, 16'hFFFF, 0, 16'd1, 2'd0); step("R5 load -1");
        put_ld(1, 16'h0000, 0, 16'd1, 2'd0); step("R5 load 0");
        put_st(1, 16'h7FFF, 0, 16'd1, 2'd3); step("R5 store max");
        put_ld(1, 16'h8000, 0, 16'd1, 2'd3); step("R5 no wrap");

        // group end timing
        put_ld(1, 16'h7FFF, 0, 16'd1, 2'd0); group_end = 1; step("R8 same cycle");
        put_ld(1, 16'h7FFF, 0, 16'd1, 2'd0); step("R8 cleared");
        put_st(0, 16'd9, 0, 16'd7, 2'd0); group_end = 1; step("R8 store with end");
        put_ld(0, 16'd9, 0, 16'd7, 2'd0); step("R8 store kept");

        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0)
                put_st($urandom_range(0, 1) == 1, rnd_val(), $urandom_range(0, 7) == 0,
                       16'($urandom_range(0, 2)), 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 4) != 0)
                put_ld($urandom_range(0, 1) == 1, rnd_val(), $urandom_range(0, 7) == 0,
                       16'($urandom_range(0, 2)), 2'($urandom_range(0, 3)));
            group_end = ($urandom_range(0, 9) == 0);
            step("R4 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule